// File: doc/BRIEF.md
# Write-Once Watchdog Timer

This block is a watchdog timer that sits on a simple register bus. A 12-bit counter counts down once per tick. A tick comes every `PRESCALE` pulses of a slow-clock enable, which gives about 256 Hz when the slow clock is 32.768 kHz and `PRESCALE` is 128. Software restarts the counter by writing a restart command that carries a key. If the counter goes below zero, the block raises a reset request. The request goes either to the whole system or to the processor only, and it stays high until the block itself is reset.

After reset, a mode register sets the reload value, the restart window, the reset options, debug halting and disabling. It accepts only one write. A later write cannot change the configuration, so software cannot stop a running watchdog. A status register shows whether the counter underflowed and whether a restart came outside the window. Reading the status register clears both flags. The same read also returns the live counter value.

Register map (2-bit address): 0 is the restart command register, 1 is the mode register, 2 is the status register. Bus reads and writes each take one cycle, and the read data is combinational from the current state.

Top module: `wdog_once`

## Requirements
- R1: After reset, the mode register reads 0x0FFF_2FFF (reload 0xFFF, window 0xFFF, reset enabled). The status register reads 0x0FFF_0000. Both reset requests are low.
- R2: The counter, seen in status bits [27:16], goes down by exactly one on every `PRESCALE`-th slow-clock enable pulse. It does not change on the pulses in between.
- R3: Only the first mode-register write after reset is accepted. Mode fields: reload [11:0], reset enable bit 13, processor-only bit 14, disable bit 15, window [27:16], debug halt bit 28. Any later write leaves the readback and the running counter unchanged, even when it sets the disable bit.
- R4: A write to register 0 restarts the counter only when bits [31:24] equal 0xA5 and bit 0 is 1. A restart reloads the counter from the reload field and clears the partial prescale count. Any other value written to register 0 has no effect.
- R5: When the counter is at 0 and one more tick arrives, the block underflows. If reset enable is set and processor-only is clear, the system reset request goes high and stays high. The counter then stays at 0, and status bit 0 (underflow) is set.
- R6: If both reset enable and processor-only are set, an underflow raises the processor reset request instead. The two requests are never high together.
- R7: If reset enable is clear, an underflow raises neither request, but the underflow flag is still set.
- R8: With the disable bit set, the counter never changes, no reset request is made, and restart commands are ignored.
- R9: With the debug halt bit set, the counter and the prescaler hold still while the debug-halt input is high. They continue when the input goes low.
- R10: A keyed restart that arrives while the counter is above the window value sets status bit 1 (window error) and does not reload the counter. A restart at or below the window value reloads the counter. A window of 0xFFF allows restarts at any time.
- R11: A status read returns the underflow and window-error flags as they stand, then clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick_i | input | 1 | One-cycle enable pulse from the slow clock |
| dbg_halt_i | input | 1 | High while the processor is halted by a debugger |
| wr_en_i | input | 1 | Single-cycle register write strobe |
| rd_en_i | input | 1 | Single-cycle register read strobe (clears status flags) |
| addr_i | input | 2 | Register select: 0 restart, 1 mode, 2 status |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the selected register |
| sys_rst_req_o | output | 1 | Sticky full-system reset request |
| cpu_rst_req_o | output | 1 | Sticky processor-only reset request |

## Verification
Most internal state shows up in the status counter field within one cycle. A prescaler that has drifted makes the counter step early or late. A lost lock bit shows as a changed mode readback or a counter jumping to a new reload value. A wrong window comparison shows up on the very next status read, either as an error flag with no reload or as a reload with no flag. Errors in the underflow logic show up on the tick after the counter reaches zero, either on the wrong reset request line or as a request that later drops. The bench sweeps small reload values through the full countdown to underflow and tries every combination of reset enable and processor-only. It also probes each restart-key case, each side of the window, and both the debug-halt and the disable settings.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int CNT_W       = 12;
    localparam int DATA_W      = 32;
    localparam int RLD_LSB     = 0;
    localparam int RSTEN_BIT   = 13;
    localparam int CPU_BIT     = 14;
    localparam int DIS_BIT     = 15;
    localparam int WIN_LSB     = 16;
    localparam int DBG_BIT     = 28;
    localparam int KEY_LSB     = 24;
    localparam int KICK_BIT    = 0;
    localparam int ST_CNT_LSB  = 16;

    typedef enum logic [1:0] {
        REG_KICK = 2'd0,
        REG_MODE = 2'd1,
        REG_STAT = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic             dbg_en;
        logic [CNT_W-1:0] window;
        logic             dis;
        logic             cpu_only;
        logic             rst_en;
        logic [CNT_W-1:0] reload;
    } mode_t;

    localparam mode_t MODE_RST = '{
        dbg_en: 1'b0, window: '1, dis: 1'b0,
        cpu_only: 1'b0, rst_en: 1'b1, reload: '1
    };

    function automatic mode_t mode_from_word(input logic [DATA_W-1:0] w);
        mode_t m;
        m.reload   = w[RLD_LSB +: CNT_W];
        m.rst_en   = w[RSTEN_BIT];
        m.cpu_only = w[CPU_BIT];
        m.dis      = w[DIS_BIT];
        m.window   = w[WIN_LSB +: CNT_W];
        m.dbg_en   = w[DBG_BIT];
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] mode_to_word(input mode_t m);
        logic [DATA_W-1:0] w;
        w = '0;
        w[RLD_LSB +: CNT_W] = m.reload;
        w[RSTEN_BIT]        = m.rst_en;
        w[CPU_BIT]          = m.cpu_only;
        w[DIS_BIT]          = m.dis;
        w[WIN_LSB +: CNT_W] = m.window;
        w[DBG_BIT]          = m.dbg_en;
        return w;
    endfunction
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int PRESCALE = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    input  logic slow_i,
    output logic tick_o
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] pcnt_d, pcnt_q;

    assign tick_o = run_i & slow_i & (pcnt_q == LAST);

    always_comb begin
        pcnt_d = pcnt_q;
        if (clr_i) begin
            pcnt_d = '0;
        end else if (run_i && slow_i) begin
            pcnt_d = tick_o ? '0 : pcnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end
endmodule

// File: rtl/wdog_mode_lock.sv
module wdog_mode_lock
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output mode_t             mode_o,
    output logic              locked_o,
    output logic              accept_o
);
    typedef struct packed {
        mode_t mode;
        logic  locked;
    } lock_st_t;

    lock_st_t st_d, st_q;

    assign accept_o = wr_i & ~st_q.locked;
    assign mode_o   = st_q.mode;
    assign locked_o = st_q.locked;

    always_comb begin
        st_d = st_q;
        if (accept_o) begin
            st_d.mode   = mode_from_word(wdata_i);
            st_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_RST, locked: 1'b0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  mode_t            mode_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             kick_i,
    input  logic             tick_i,
    input  logic             clr_flags_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expired_o,
    output logic             uflow_o,
    output logic             err_o,
    output logic             req_sys_o,
    output logic             req_cpu_o,
    output logic             restart_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             expired;
        logic             uflow;
        logic             err;
        logic             req_sys;
        logic             req_cpu;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    kick_live, in_window, load_ok;

    assign kick_live = kick_i & ~mode_i.dis & ~st_q.expired;
    assign in_window = (st_q.cnt <= mode_i.window);
    assign load_ok   = load_i & ~st_q.expired;
    assign restart_o = load_ok | (kick_live & in_window);

    always_comb begin
        st_d = st_q;
        if (clr_flags_i) begin
            st_d.uflow = 1'b0;
            st_d.err   = 1'b0;
        end
        if (kick_live && !in_window) begin
            st_d.err = 1'b1;
        end
        if (load_ok) begin
            st_d.cnt = load_val_i;
        end else if (kick_live && in_window) begin
            st_d.cnt = mode_i.reload;
        end else if (tick_i) begin
            if (st_q.cnt == '0) begin
                st_d.expired = 1'b1;
                st_d.uflow   = 1'b1;
                st_d.req_sys = mode_i.rst_en & ~mode_i.cpu_only;
                st_d.req_cpu = mode_i.rst_en &  mode_i.cpu_only;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: MODE_RST.reload, expired: 1'b0, uflow: 1'b0,
                      err: 1'b0, req_sys: 1'b0, req_cpu: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign expired_o = st_q.expired;
    assign uflow_o   = st_q.uflow;
    assign err_o     = st_q.err;
    assign req_sys_o = st_q.req_sys;
    assign req_cpu_o = st_q.req_cpu;
endmodule

// File: rtl/wdog_once.sv
module wdog_once
    import wdog_pkg::*;
#(
    parameter int           PRESCALE = 128,
    parameter logic [7:0]   KEY      = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick_i,
    input  logic              dbg_halt_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              sys_rst_req_o,
    output logic              cpu_rst_req_o
);
    mode_t            mode;
    logic             locked, mode_accept;
    logic             kick, mode_wr, stat_rd, run, tick, restart;
    logic [CNT_W-1:0] cnt;
    logic             expired, uflow, err;

    assign kick    = wr_en_i && (addr_i == REG_KICK)
                     && (wdata_i[KEY_LSB +: 8] == KEY) && wdata_i[KICK_BIT];
    assign mode_wr = wr_en_i && (addr_i == REG_MODE);
    assign stat_rd = rd_en_i && (addr_i == REG_STAT);
    assign run     = ~mode.dis & ~(mode.dbg_en & dbg_halt_i) & ~expired;

    wdog_mode_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (mode_wr),
        .wdata_i  (wdata_i),
        .mode_o   (mode),
        .locked_o (locked),
        .accept_o (mode_accept)
    );

    wdog_prescale #(.PRESCALE(PRESCALE)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (restart),
        .run_i  (run),
        .slow_i (slow_tick_i),
        .tick_o (tick)
    );

    wdog_count u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .load_i      (mode_accept),
        .load_val_i  (wdata_i[RLD_LSB +: CNT_W]),
        .kick_i      (kick),
        .tick_i      (tick),
        .clr_flags_i (stat_rd),
        .cnt_o       (cnt),
        .expired_o   (expired),
        .uflow_o     (uflow),
        .err_o       (err),
        .req_sys_o   (sys_rst_req_o),
        .req_cpu_o   (cpu_rst_req_o),
        .restart_o   (restart)
    );

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            REG_MODE: rdata_o = mode_to_word(mode);
            REG_STAT: begin
                rdata_o[ST_CNT_LSB +: CNT_W] = cnt;
                rdata_o[1]                   = err;
                rdata_o[0]                   = uflow;
            end
            default:  rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/wdog_once_chk.sv
module wdog_once_chk
    import wdog_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input mode_t            mode,
    input logic             locked,
    input logic [CNT_W-1:0] cnt,
    input logic             wr_en_i,
    input logic             dbg_halt_i,
    input logic             sys_rst_req_o,
    input logic             cpu_rst_req_o
);
    // R5
    sys_req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req_o |=> sys_rst_req_o);

    // R5
    cpu_req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst_req_o |=> cpu_rst_req_o);

    // R6
    req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sys_rst_req_o && cpu_rst_req_o));

    // R3
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(mode) && locked);

    // R8
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.dis && !sys_rst_req_o && !cpu_rst_req_o)
        |=> $stable(cnt) && !sys_rst_req_o && !cpu_rst_req_o);

    // R9
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.dbg_en && dbg_halt_i && !wr_en_i) |=> $stable(cnt));

    // R2
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> (cnt == $past(cnt)) || (cnt == $past(cnt) - 12'd1));
endmodule

bind wdog_once wdog_once_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode          (mode),
    .locked        (locked),
    .cnt           (cnt),
    .wr_en_i       (wr_en_i),
    .dbg_halt_i    (dbg_halt_i),
    .sys_rst_req_o (sys_rst_req_o),
    .cpu_rst_req_o (cpu_rst_req_o)
);

// File: tb/wdog_once_bench.sv
module wdog_once_bench;
    localparam int PS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow = 1'b0;
    logic        dbg = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sys_req, cpu_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdog_once #(.PRESCALE(PS), .KEY(8'hA5)) u_wdog_once (
        .clk           (clk),
        .rst_n         (rst_n),
        .slow_tick_i   (slow),
        .dbg_halt_i    (dbg),
        .wr_en_i       (wr_en),
        .rd_en_i       (rd_en),
        .addr_i        (addr),
        .wdata_i       (wdata),
        .rdata_o       (rdata),
        .sys_rst_req_o (sys_req),
        .cpu_rst_req_o (cpu_req)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; dbg = 1'b0; slow = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic pulses(input int n);
        repeat (n) begin
            @(negedge clk);
            slow = 1'b1;
            @(posedge clk);
            #1 slow = 1'b0;
        end
    endtask

    task automatic ticks(input int n);
        pulses(n * PS);
    endtask

    task automatic cnt_is(input string tag, input int exp);
        logic [31:0] s;
        rd(2'd2, s);
        chk(tag, {20'd0, s[27:16]}, 32'(exp));
    endtask

    initial begin
        logic [31:0] s;
        do_reset();

        // R1: reset state
        rd(2'd1, s); chk("R1 mode reset", s, 32'h0FFF_2FFF);
        rd(2'd2, s); chk("R1 status reset", s, 32'h0FFF_0000);
        chk("R1 requests low", {30'd0, sys_req, cpu_req}, 32'd0);

        // R2: prescaler boundary
        do_reset();
        wr(2'd1, 32'h0FFF_2014);
        cnt_is("R2 loaded", 20);
        pulses(PS - 1); cnt_is("R2 partial prescale", 20);
        pulses(1);      cnt_is("R2 one tick", 19);
        ticks(3);       cnt_is("R2 three ticks", 16);

        // R5, R11: full countdown sweep over small reload values
        for (int r = 0; r <= 6; r++) begin
            do_reset();
            wr(2'd1, 32'h0FFF_2000 | 32'(r));
            cnt_is("R5 load", r);
            for (int t = 1; t <= r; t++) begin
                ticks(1);
                cnt_is("R5 countdown", r - t);
                chk("R5 no early request", {31'd0, sys_req}, 32'd0);
            end
            ticks(1);
            chk("R5 system request", {30'd0, sys_req, cpu_req}, 32'd2);
            rd(2'd2, s); chk("R11 underflow flag seen", s, 32'h0000_0001);
            ticks(2);
            chk("R5 request held", {30'd0, sys_req, cpu_req}, 32'd2);
            rd(2'd2, s); chk("R11 flag cleared, counter parked", s, 32'h0);
        end

        // R6, R7: reset option combinations
        for (int en = 0; en < 2; en++) begin
            for (int cpu = 0; cpu < 2; cpu++) begin
                do_reset();
                wr(2'd1, 32'h0FFF_0001 | (32'(en) << 13) | (32'(cpu) << 14));
                ticks(2);
                chk(cpu != 0 ? "R6 request routing" : "R7 request routing",
                    {30'd0, sys_req, cpu_req},
                    {30'd0, 1'(en != 0 && cpu == 0), 1'(en != 0 && cpu != 0)});
                rd(2'd2, s); chk("R7 underflow flag", {31'd0, s[0]}, 32'd1);
            end
        end

        // R3: write-once mode, later disable has no effect
        do_reset();
        wr(2'd1, 32'h0FFF_2005);
        wr(2'd1, 32'h0FFF_A009);
        rd(2'd1, s); chk("R3 readback kept", s, 32'h0FFF_2005);
        ticks(2); cnt_is("R3 still counting", 3);

        // R4: restart key
        do_reset();
        wr(2'd1, 32'h0FFF_200A);
        ticks(3); cnt_is("R4 before restart", 7);
        wr(2'd0, 32'h5A00_0001); cnt_is("R4 wrong key", 7);
        wr(2'd0, 32'hA500_0000); cnt_is("R4 missing restart bit", 7);
        pulses(PS - 2);
        wr(2'd0, 32'hA500_0001); cnt_is("R4 restart reloads", 10);
        pulses(PS - 1); cnt_is("R4 prescale cleared", 10);
        pulses(1);      cnt_is("R4 tick after restart", 9);

        // R10: restart window
        do_reset();
        wr(2'd1, 32'h0005_200A);
        ticks(2);
        wr(2'd0, 32'hA500_0001);
        rd(2'd2, s); chk("R10 early restart rejected", s, 32'h0008_0002);
        ticks(3); cnt_is("R10 at window edge", 5);
        wr(2'd0, 32'hA500_0001);
        rd(2'd2, s); chk("R10 restart in window", s, 32'h000A_0000);

        // R8: disabled
        do_reset();
        wr(2'd1, 32'h0FFF_A003);
        ticks(10); cnt_is("R8 frozen", 3);
        chk("R8 no request", {30'd0, sys_req, cpu_req}, 32'd0);
        wr(2'd0, 32'hA500_0001);
        rd(2'd2, s); chk("R8 restart ignored", s, 32'h0003_0000);

        // R9: debug halt
        do_reset();
        wr(2'd1, 32'h1FFF_2008);
        dbg = 1'b1;
        ticks(4); cnt_is("R9 halted", 8);
        dbg = 1'b0;
        ticks(2); cnt_is("R9 resumed", 6);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired got=%0h exp=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule